// File: doc/BRIEF.md
# Bidirectional Row Scan Selector with Alternating Drive Levels

This block is the row-scanning half of a large dot-matrix display driver. A single scan bit enters at `scan_in`. It moves one stage through a chain of `NUM_CH` stages on every falling edge of the line clock `line_clk`, and it leaves through `scan_carry`. Several copies can be chained, with each `scan_carry` feeding the next `scan_in`. A direction input picks which end of the chain the bit enters and which end it leaves. A width input can shorten the chain to its lower half.

Each output channel turns one data bit and the frame alternation input `ac_phase` into one of four 2-bit drive-level codes. The four codes are V1 = 2'b00, V2 = 2'b01, V3 = 2'b10 and V4 = 2'b11. V1 and V2 are the selected levels. V3 and V4 are the non-selected levels. In row mode the data bit is the channel's scan stage. In column mode the same encoder reads a display-data vector latched outside this block, and the scan chain is frozen.

`line_clk` is a level signal that is synchronous to `clk`. Its falling edge is detected inside the block. The analog level switches and the supplies are outside this block.

Top module: `row_scan_ac_drv`

## Requirements
- R1: While reset is active, and until the first shift after it, every scan stage is clear. `scan_carry` is 0 and every channel in row mode shows a non-selected level: V3 (2'b10) with `ac_phase`=0, or V4 (2'b11) with `ac_phase`=1.
- R2: In row mode (`mode_col`=0) the scan chain advances by exactly one stage in the clock cycle where `line_clk` goes from 1 to 0. It does not change while `line_clk` stays high, stays low, or rises.
- R3: With `dir_fwd`=1, `scan_in` enters channel 0 and each stage takes the value of the next lower channel. `scan_carry` shows the last active channel: `NUM_CH`-1, or `NUM_CH`/2-1 in half width.
- R4: With `dir_fwd`=0, `scan_in` enters the last active channel and each stage takes the value of the next higher channel. `scan_carry` shows channel 0.
- R5: With `half_width`=1, only channels 0 to `NUM_CH`/2-1 shift. Channels `NUM_CH`/2 and above hold their stage and always output a non-selected level (row mode) or the level for data 0 (column mode).
- R6: In column mode each channel `i` is coded from `col_data[i]` and `ac_phase` as follows: data 1 with phase 1 gives 2'b00, data 1 with phase 0 gives 2'b01, data 0 with phase 1 gives 2'b10, data 0 with phase 0 gives 2'b11.
- R7: In row mode each channel is coded from its stage and `ac_phase` as follows: selected with phase 1 gives 2'b01, selected with phase 0 gives 2'b00, unselected with phase 1 gives 2'b11, unselected with phase 0 gives 2'b10.
- R8: In column mode falling edges of `line_clk` do not move the scan chain. On return to row mode the outputs show the stages as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| line_clk | input | 1 | Line clock level; a 1-to-0 transition triggers one shift |
| mode_col | input | 1 | 1 = column function, 0 = row scan function |
| dir_fwd | input | 1 | 1 = scan toward higher channels, 0 = toward lower channels |
| half_width | input | 1 | 1 = only the lower `NUM_CH`/2 channels are active |
| ac_phase | input | 1 | Frame alternation signal selecting the drive polarity |
| scan_in | input | 1 | Scan data entering the chain (from the previous chip's carry) |
| col_data | input | NUM_CH | Latched display data used in column mode |
| scan_carry | output | 1 | Scan data leaving the active end of the chain |
| lvl | output | 2*NUM_CH | Drive-level code per channel; channel i at bits [2i+1:2i] |

## Verification
Some properties are checked on every cycle:
- the chain stays still whenever no falling line-clock edge is seen, or whenever column mode is active;
- the entry stage takes `scan_in` in each direction;
- the upper half stays non-selected in half width;
- the low bit of every code follows the alternation polarity of the current mode.

Other behaviour shows only through the bench's scenarios, run against an independent model of the chain:
- the full travel of a token to `scan_carry` after exactly 160 or 80 shifts, in both directions;
- the exact four-way code mapping for selected and unselected channels;
- the chain being unchanged after line-clock activity in column mode.

// File: rtl/rsd_pkg.sv
package rsd_pkg;

  typedef enum logic [1:0] {
    LVL_V1 = 2'b00,
    LVL_V2 = 2'b01,
    LVL_V3 = 2'b10,
    LVL_V4 = 2'b11
  } drv_level_e;

  // Column: on -> V1/V2 by phase, off -> V3/V4.
  // Row: polarity of the selected and non-selected pair is swapped.
  function automatic drv_level_e level_code(input logic col, input logic on, input logic phase);
    drv_level_e code;
    if (col) begin
      if (on) code = phase ? LVL_V1 : LVL_V2;
      else    code = phase ? LVL_V3 : LVL_V4;
    end else begin
      if (on) code = phase ? LVL_V2 : LVL_V1;
      else    code = phase ? LVL_V4 : LVL_V3;
    end
    return code;
  endfunction

endpackage

// File: rtl/rsd_edge_det.sv
module rsd_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic fall
);

  logic line_q;
  logic line_d;

  always_comb begin
    line_d = line_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= 1'b0;
    else        line_q <= line_d;
  end

  assign fall = line_q & ~line_in;

endmodule

// File: rtl/rsd_scan_reg.sv
module rsd_scan_reg #(
  parameter int NUM_CH = 160
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              dir_fwd,
  input  logic              half_width,
  input  logic              scan_in,
  output logic [NUM_CH-1:0] stage_q,
  output logic              carry
);

  localparam int HALF = NUM_CH / 2;

  logic [NUM_CH-1:0] stage_d;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_stage
    logic src_fwd;
    logic src_rev;
    logic live;

    if (i == 0) begin : g_fwd_head
      assign src_fwd = scan_in;
    end else begin : g_fwd_body
      assign src_fwd = stage_q[i-1];
    end

    if (i == NUM_CH - 1) begin : g_rev_head
      assign src_rev = scan_in;
    end else if (i == HALF - 1) begin : g_rev_half
      assign src_rev = half_width ? scan_in : stage_q[i+1];
    end else begin : g_rev_body
      assign src_rev = stage_q[i+1];
    end

    if (i < HALF) begin : g_low
      assign live = 1'b1;
    end else begin : g_high
      assign live = ~half_width;
    end

    assign stage_d[i] = (shift_en && live) ? (dir_fwd ? src_fwd : src_rev)
                                           : stage_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign carry = dir_fwd ? (half_width ? stage_q[HALF-1] : stage_q[NUM_CH-1])
                         : stage_q[0];

endmodule

// File: rtl/rsd_level_enc.sv
module rsd_level_enc #(
  parameter int NUM_CH = 160
) (
  input  logic                mode_col,
  input  logic                half_width,
  input  logic                ac_phase,
  input  logic [NUM_CH-1:0]   stage,
  input  logic [NUM_CH-1:0]   col_data,
  output logic [2*NUM_CH-1:0] lvl
);

  localparam int HALF = NUM_CH / 2;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic raw;
    logic on;

    assign raw = mode_col ? col_data[i] : stage[i];

    if (i < HALF) begin : g_low
      assign on = raw;
    end else begin : g_high
      assign on = raw & ~half_width;
    end

    assign lvl[2*i +: 2] = rsd_pkg::level_code(mode_col, on, ac_phase);
  end

endmodule

// File: rtl/row_scan_ac_drv.sv
module row_scan_ac_drv #(
  parameter int NUM_CH = 160
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                line_clk,
  input  logic                mode_col,
  input  logic                dir_fwd,
  input  logic                half_width,
  input  logic                ac_phase,
  input  logic                scan_in,
  input  logic [NUM_CH-1:0]   col_data,
  output logic                scan_carry,
  output logic [2*NUM_CH-1:0] lvl
);

  logic [1:0]        rst_pipe;
  logic              rst_int_n;
  logic              line_fall;
  logic              shift_en;
  logic [NUM_CH-1:0] stage_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end

  assign rst_int_n = rst_pipe[1];

  rsd_edge_det u_edge (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .line_in (line_clk),
    .fall    (line_fall)
  );

  // the chain is a row function only
  assign shift_en = line_fall & ~mode_col;

  rsd_scan_reg #(.NUM_CH(NUM_CH)) u_scan (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .shift_en   (shift_en),
    .dir_fwd    (dir_fwd),
    .half_width (half_width),
    .scan_in    (scan_in),
    .stage_q    (stage_q),
    .carry      (scan_carry)
  );

  rsd_level_enc #(.NUM_CH(NUM_CH)) u_enc (
    .mode_col   (mode_col),
    .half_width (half_width),
    .ac_phase   (ac_phase),
    .stage      (stage_q),
    .col_data   (col_data),
    .lvl        (lvl)
  );

endmodule

// File: rtl/rsd_checker.sv
module rsd_checker #(
  parameter int NUM_CH = 160
) (
  input logic                clk,
  input logic                rst_n,
  input logic                line_clk,
  input logic                mode_col,
  input logic                dir_fwd,
  input logic                half_width,
  input logic                ac_phase,
  input logic                scan_in,
  input logic                scan_carry,
  input logic [2*NUM_CH-1:0] lvl,
  input logic [NUM_CH-1:0]   stage
);

  localparam int HALF = NUM_CH / 2;

  logic prev_line;
  logic fall_seen;
  logic upper_nonsel;
  logic phase_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_line <= 1'b0;
    else        prev_line <= line_clk;
  end

  assign fall_seen = prev_line & ~line_clk;

  always_comb begin
    upper_nonsel = 1'b1;
    phase_ok     = 1'b1;
    for (int i = 0; i < NUM_CH; i++) begin
      if (i >= HALF && lvl[2*i+1] != 1'b1) upper_nonsel = 1'b0;
      if (lvl[2*i] != (mode_col ? ~ac_phase : ac_phase)) phase_ok = 1'b0;
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RST_CLEAR: assert (stage == '0 && scan_carry == 1'b0)   // R1
        else $error("scan chain not clear in reset");
    end else begin
      if (half_width && !mode_col) begin
        AST_HALF_UPPER_IDLE: assert (upper_nonsel)                 // R5
          else $error("upper channel selected in half width");
      end
      AST_PHASE_POLARITY: assert (phase_ok)                        // R7
        else $error("low code bit does not follow phase");
    end
  end

  AST_HOLD_NO_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_seen |=> $stable(stage));                                // R2

  AST_FWD_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_seen && !mode_col && dir_fwd) |=> stage[0] == $past(scan_in)); // R3

  AST_REV_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_seen && !mode_col && !dir_fwd && !half_width)
      |=> stage[NUM_CH-1] == $past(scan_in));                      // R4

  AST_COL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    mode_col |=> $stable(stage));                                  // R8

endmodule

bind row_scan_ac_drv rsd_checker #(.NUM_CH(NUM_CH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_int_n),
  .line_clk   (line_clk),
  .mode_col   (mode_col),
  .dir_fwd    (dir_fwd),
  .half_width (half_width),
  .ac_phase   (ac_phase),
  .scan_in    (scan_in),
  .scan_carry (scan_carry),
  .lvl        (lvl),
  .stage      (stage_q)
);

// File: tb/sim_row_scan_ac_drv.sv
module sim_row_scan_ac_drv;

  localparam int N    = 160;
  localparam int HALF = N / 2;
  localparam int NVEC = 12;
  // each entry: {dir_fwd, half_width, ac_phase, scan_in}
  localparam logic [3:0] VEC [NVEC] = '{
    4'b1011, 4'b1000, 4'b1011, 4'b1000,
    4'b0011, 4'b0000, 4'b0111, 4'b0100,
    4'b1111, 4'b1101, 4'b0010, 4'b1001
  };

  logic           clk;
  logic           rst_n;
  logic           r_sclk, r_mode, r_dir, r_half, r_m, r_e;
  logic [N-1:0]   r_col;
  logic           carry;
  logic [2*N-1:0] lvl;

  int n_run;
  int n_fail;
  bit ms [N];

  row_scan_ac_drv #(.NUM_CH(N)) u0 (
    .clk(clk), .rst_n(rst_n), .line_clk(r_sclk), .mode_col(r_mode),
    .dir_fwd(r_dir), .half_width(r_half), .ac_phase(r_m), .scan_in(r_e),
    .col_data(r_col), .scan_carry(carry), .lvl(lvl)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [1:0] exp_code(input int c);
    logic d;
    d = r_mode ? r_col[c] : ms[c];
    if (r_half && c >= HALF) d = 1'b0;
    if (r_mode) return d ? (r_m ? 2'b00 : 2'b01) : (r_m ? 2'b10 : 2'b11);
    else        return d ? (r_m ? 2'b01 : 2'b00) : (r_m ? 2'b11 : 2'b10);
  endfunction

  function automatic logic exp_carry();
    if (r_dir) return r_half ? ms[HALF-1] : ms[N-1];
    return ms[0];
  endfunction

  task automatic chk(input string tag, input logic [1:0] got, input logic [1:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic check_all(input string tag);
    int bad;
    bad = -1;
    for (int c = 0; c < N; c++)
      if (bad < 0 && lvl[2*c +: 2] !== exp_code(c)) bad = c;
    n_run++;
    if (bad >= 0) begin
      n_fail++;
      $display("FAIL %s: channel %0d got %b expected %b", tag, bad,
               lvl[2*bad +: 2], exp_code(bad));
    end
    chk({tag, " carry"}, {1'b0, carry}, {1'b0, exp_carry()});
  endtask

  task automatic model_shift(input logic e);
    bit nx [N];
    int last;
    last = r_half ? HALF - 1 : N - 1;
    for (int i = 0; i < N; i++) begin
      nx[i] = ms[i];
      if (!r_half || i < HALF) begin
        if (r_dir) nx[i] = (i == 0) ? e : ms[i-1];
        else       nx[i] = (i == last) ? e : ms[i+1];
      end
    end
    ms = nx;
  endtask

  task automatic shift_one(input logic e);
    @(negedge clk); r_e = e; r_sclk = 1'b1;
    @(negedge clk); r_sclk = 1'b0;
    @(negedge clk);
    if (!r_mode) model_shift(e);
  endtask

  task automatic flush();
    r_mode = 1'b0; r_dir = 1'b1; r_half = 1'b0;
    repeat (N) shift_one(1'b0);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    n_run = 0; n_fail = 0;
    for (int i = 0; i < N; i++) ms[i] = 1'b0;
    rst_n = 1'b1;
    r_sclk = 1'b0; r_mode = 1'b0; r_dir = 1'b1; r_half = 1'b0;
    r_m = 1'b0; r_e = 1'b0; r_col = '0;
    #1 rst_n = 1'b0;
    repeat (4) @(negedge clk);
    // R1: reset state with both phases
    check_all("R1 reset phase0");
    chk("R1 ch0 phase0", lvl[1:0], 2'b10);
    r_m = 1'b1; #1;
    chk("R1 ch159 phase1", lvl[2*N-1 -: 2], 2'b11);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_all("R1 after release");

    // table walk
    for (int v = 0; v < NVEC; v++) begin
      {r_dir, r_half, r_m} = VEC[v][3:1];
      shift_one(VEC[v][0]);
      check_all(r_half ? "R5 vector" : (r_dir ? "R3 vector" : "R4 vector"));
    end

    // R2: no shift while line clock high or on its rise
    flush();
    @(negedge clk); r_m = 1'b1; r_e = 1'b1; r_sclk = 1'b1;
    repeat (5) @(negedge clk);
    chk("R2 held high ch0", lvl[1:0], 2'b11);
    check_all("R2 held high");
    r_sclk = 1'b0;
    @(negedge clk);
    model_shift(1'b1);
    chk("R2 fall ch0 R7 selected phase1", lvl[1:0], 2'b01);
    repeat (3) @(negedge clk);
    check_all("R2 single step");

    // R3: full forward travel of one token
    flush();
    r_m = 1'b0;
    shift_one(1'b1);
    chk("R7 selected phase0 ch0", lvl[1:0], 2'b00);
    repeat (N - 2) shift_one(1'b0);
    chk("R3 carry before end", {1'b0, carry}, 2'b00);
    shift_one(1'b0);
    chk("R3 carry at end", {1'b0, carry}, 2'b01);
    chk("R3 last ch selected", lvl[2*N-1 -: 2], 2'b00);
    shift_one(1'b0);
    chk("R3 carry after exit", {1'b0, carry}, 2'b00);

    // R4: full reverse travel
    flush();
    r_dir = 1'b0;
    shift_one(1'b1);
    chk("R4 entry ch159", lvl[2*N-1 -: 2], 2'b00);
    repeat (N - 1) shift_one(1'b0);
    chk("R4 carry at ch0", {1'b0, carry}, 2'b01);
    check_all("R4 travel");

    // R5: half width forward and reverse
    flush();
    r_half = 1'b1; r_dir = 1'b1;
    shift_one(1'b1);
    repeat (HALF - 1) shift_one(1'b0);
    chk("R5 fwd carry", {1'b0, carry}, 2'b01);
    shift_one(1'b0);
    chk("R5 ch80 unselected", lvl[2*HALF +: 2], 2'b10);
    chk("R5 fwd carry exit", {1'b0, carry}, 2'b00);
    r_dir = 1'b0;
    shift_one(1'b1);
    chk("R5 rev entry ch79", lvl[2*(HALF-1) +: 2], 2'b00);
    repeat (HALF - 1) shift_one(1'b0);
    chk("R5 rev carry", {1'b0, carry}, 2'b01);
    check_all("R5 half travel");

    // R6 and R8: column mapping, chain frozen
    flush();
    r_m = 1'b1;
    shift_one(1'b1);
    shift_one(1'b0);
    r_mode = 1'b1;
    r_col = '0; r_col[0] = 1'b1; r_col[N-1] = 1'b1;
    #1;
    chk("R6 d1 phase1", lvl[1:0], 2'b00);
    chk("R6 d0 phase1", lvl[3:2], 2'b10);
    r_m = 1'b0; #1;
    chk("R6 d1 phase0", lvl[1:0], 2'b01);
    chk("R6 d0 phase0", lvl[3:2], 2'b11);
    r_half = 1'b1; #1;
    chk("R5 column upper masked", lvl[2*N-1 -: 2], 2'b11);
    r_half = 1'b0;
    repeat (3) shift_one(1'b1);
    check_all("R6 column all");
    r_mode = 1'b0; r_m = 1'b1;
    @(negedge clk);
    chk("R8 chain kept ch1", lvl[3:2], 2'b01);
    check_all("R8 after column");

    summary();
  end

endmodule